// File: doc/BRIEF.md
# Bit-Plane Pixel Store with Run-Time Precision

This block stores luminance samples of `PIX_W` bits. Each bit position of every pixel is held in its own one-bit-wide sub-array, so the store is made of `PIX_W` bit-planes. All planes share the write and read addresses. Plane `PIX_W-1` holds the most significant bit.

A run-time precision input selects how many of the most significant planes take part in reads. The remaining low-order planes are idle, and their enable outputs are deasserted so that a memory macro can be put into a low-power state. Idle planes return zero, so read data comes back left-aligned at the chosen precision. Writes always update every plane, so raising the precision later exposes full-precision data. A search engine can use this to compute coarse costs at low precision and then refine the result at full precision.

A precision change is taken only in a cycle with no read request, so a read burst never sees its precision change part way through. The block also reports the active precision and the number of idle planes.

Top module: `bitplane_store`

## Requirements
- R1: During and after reset, `rd_valid_o` is 0, the active precision is `PIX_W`, all bits of `plane_en_o` are 1 and `idle_planes_o` is 0.
- R2: A write updates all `PIX_W` planes at `wr_addr_i`, whatever the active precision is.
- R3: A read requested at a clock edge returns its data on `rd_data_o` after that edge, with `rd_valid_o` high in the same cycle. `rd_valid_o` is low in the cycle after an edge without a read.
- R4: Read data carries the stored bits at positions `PIX_W-1` down to `PIX_W-Dr`, where Dr is the active precision. Every lower bit position reads as 0.
- R5: Bit i of `plane_en_o` is 1 exactly when i >= `PIX_W` - Dr, so exactly Dr of its bits are set.
- R6: `idle_planes_o` equals `PIX_W` - Dr.
- R7: `prec_i` is sampled into the active precision only at a clock edge where `rd_i` is 0. While `rd_i` stays high, the active precision does not change.
- R8: A sampled `prec_i` of 0 becomes precision 1, and a value above `PIX_W` becomes `PIX_W`. Values from 1 to `PIX_W` are taken as they are.
- R9: A read and a write to the same address at the same edge return the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write pixel address |
| wr_data_i | input | PIX_W | Full-precision write sample |
| rd_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read pixel address |
| prec_i | input | PREC_W | Requested precision (number of top planes) |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | PIX_W | Left-aligned read sample |
| plane_en_o | output | PIX_W | Per-plane active enable |
| active_prec_o | output | PREC_W | Precision currently applied |
| idle_planes_o | output | PREC_W | Number of idle low-order planes |

## Verification
The bench builds the block with its default values: 8-bit samples, a 64-entry address space and a 4-bit precision input. A 4-bit precision input can carry values from 9 to 15, so the upper clamp path is reached along with a request of 0. Eight planes allow a sweep of every legal precision from 1 to 8 with all-ones data, so each bit boundary is exercised. The bench also covers a precision request that arrives in the middle of a read burst, a write made while planes are idle, and a read and write to the same address at the same edge.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    PLANE_IDLE   = 1'b0,
    PLANE_ACTIVE = 1'b1
  } plane_mode_e;
endpackage

// File: rtl/bp_plane.sv
module bp_plane #(
  parameter int ADDR_W = 6,
  localparam int Depth = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bp_pkg::plane_mode_e mode_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_bit_o
);
  logic [Depth-1:0] mem_q;
  logic             rd_bit_q;

  // writes ignore mode: every plane stays coherent
  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_addr_i] <= wr_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_bit_q <= 1'b0;
    else if (rd_i) rd_bit_q <= (mode_i == bp_pkg::PLANE_ACTIVE) ? mem_q[rd_addr_i] : 1'b0;
  end

  assign rd_bit_o = rd_bit_q;

  // R4
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i == bp_pkg::PLANE_IDLE) |=> !rd_bit_o);
endmodule

// File: rtl/bp_prec_ctrl.sv
module bp_prec_ctrl #(
  parameter int PIX_W = 8,
  localparam int PrecW = $clog2(PIX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [PrecW-1:0] prec_i,
  output logic [PrecW-1:0] prec_o,
  output logic [PIX_W-1:0] plane_en_o,
  output logic [PrecW-1:0] idle_o
);
  localparam logic [PrecW-1:0] FullPrec = PrecW'(PIX_W);

  logic [PrecW-1:0] prec_q, prec_clamped;

  always_comb begin
    if (prec_i == '0)          prec_clamped = PrecW'(1);
    else if (prec_i > FullPrec) prec_clamped = FullPrec;
    else                        prec_clamped = prec_i;
  end

  // only retune between accesses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prec_q <= FullPrec;
    else if (!rd_i) prec_q <= prec_clamped;
  end

  for (genvar i = 0; i < PIX_W; i++) begin : g_en
    assign plane_en_o[i] = int'(prec_q) > (PIX_W - 1 - i);
  end

  assign prec_o = prec_q;
  assign idle_o = FullPrec - prec_q;

  // R7
  prec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> $stable(prec_o));
  // R8
  prec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prec_o >= PrecW'(1)) && (prec_o <= FullPrec));
endmodule

// File: rtl/bitplane_store.sv
module bitplane_store #(
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 6,
  localparam int PrecW = $clog2(PIX_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [PrecW-1:0]  prec_i,
  output logic              rd_valid_o,
  output logic [PIX_W-1:0]  rd_data_o,
  output logic [PIX_W-1:0]  plane_en_o,
  output logic [PrecW-1:0]  active_prec_o,
  output logic [PrecW-1:0]  idle_planes_o
);
  logic [PIX_W-1:0] plane_en;
  logic [PIX_W-1:0] rd_bits;
  logic             rd_valid_q;

  bp_prec_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .prec_i     (prec_i),
    .prec_o     (active_prec_o),
    .plane_en_o (plane_en),
    .idle_o     (idle_planes_o)
  );

  for (genvar p = 0; p < PIX_W; p++) begin : g_plane
    bp_pkg::plane_mode_e mode;
    assign mode = plane_en[p] ? bp_pkg::PLANE_ACTIVE : bp_pkg::PLANE_IDLE;
    bp_plane #(.ADDR_W(ADDR_W)) u_plane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode),
      .wr_i      (wr_i),
      .wr_addr_i (wr_addr_i),
      .wr_bit_i  (wr_data_i[p]),
      .rd_i      (rd_i),
      .rd_addr_i (rd_addr_i),
      .rd_bit_o  (rd_bits[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_q <= 1'b0;
    else         rd_valid_q <= rd_i;
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_bits;
  assign plane_en_o = plane_en;

  // R4
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ((rd_data_o & ~$past(plane_en_o)) == '0));
  // R5
  en_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(plane_en_o) == int'(active_prec_o));
  // R5
  msb_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plane_en_o[PIX_W-1]);
  // R6
  idle_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idle_planes_o) + int'(active_prec_o) == PIX_W);
endmodule

// File: tb/bitplane_store_test.sv
module bitplane_store_test;
  localparam int PERIOD = 10;
  localparam int PIX_W  = 8;
  localparam int ADDR_W = 6;
  localparam int PW     = $clog2(PIX_W + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, rd = 0;
  logic [ADDR_W-1:0] wa = '0, ra = '0;
  logic [PIX_W-1:0]  wd = '0;
  logic [PW-1:0]     prec = PW'(PIX_W);
  logic              rd_valid;
  logic [PIX_W-1:0]  rd_data, plane_en;
  logic [PW-1:0]     act_prec, idle;

  int vec_cnt = 0, err_cnt = 0;

  // reference model state
  int m_mem [64];
  int m_prec = PIX_W;
  bit m_valid = 0;
  int m_data = 0;

  always #(PERIOD/2) clk = ~clk;

  bitplane_store #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_i(rd), .rd_addr_i(ra), .prec_i(prec), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .plane_en_o(plane_en), .active_prec_o(act_prec),
    .idle_planes_o(idle)
  );

  function automatic int top_mask(int p);
    return ((1 << PIX_W) - 1) ^ ((1 << (PIX_W - p)) - 1);
  endfunction

  function automatic int clamp(int p);
    if (p < 1) return 1;
    if (p > PIX_W) return PIX_W;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prec  <= PIX_W;
      m_valid <= 0;
    end else begin
      m_valid <= rd;
      if (rd) m_data <= m_mem[ra] & top_mask(m_prec);
      if (wr) m_mem[wa] = int'(wd);
      if (!rd) m_prec <= clamp(int'(prec));
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk(rd_valid == m_valid, "R3 valid", int'(rd_valid), int'(m_valid));
    if (m_valid) chk(int'(rd_data) == m_data, "R4 data", int'(rd_data), m_data);
    chk(int'(plane_en) == top_mask(m_prec), "R5 plane_en", int'(plane_en), top_mask(m_prec));
    chk(int'(idle) == PIX_W - m_prec, "R6 idle", int'(idle), PIX_W - m_prec);
    chk(int'(act_prec) == m_prec, "R7 prec", int'(act_prec), m_prec);
  end

  task automatic step(bit w, int a_w, int d, bit r, int a_r, int p);
    wr = w; wa = ADDR_W'(a_w); wd = PIX_W'(d);
    rd = r; ra = ADDR_W'(a_r); prec = PW'(p);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    err_cnt++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 during reset
    chk(!rd_valid && plane_en == 8'hFF && idle == 0 && int'(act_prec) == PIX_W,
        "R1 reset", int'(plane_en), 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after reset
    chk(!rd_valid && plane_en == 8'hFF && idle == 0, "R1 post", int'(plane_en), 8'hFF);

    for (int i = 0; i < 16; i++) step(1, i, (i * 37 + 5) & 8'hFF, 0, 0, 8);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, i, 8);
    step(0, 0, 0, 0, 0, 3);
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 15 - i, 3);
    step(0, 0, 0, 0, 0, 3);

    // R2: write while low planes idle, read back at full precision
    step(1, 5, 8'h5A, 0, 0, 3);
    step(0, 0, 0, 0, 0, 8);
    step(0, 0, 0, 1, 5, 8);
    chk(rd_valid && rd_data == 8'h5A, "R2 write all planes", int'(rd_data), 8'h5A);
    step(0, 0, 0, 0, 0, 8);

    // R7: request arrives mid-burst
    step(0, 0, 0, 1, 1, 2);
    step(0, 0, 0, 1, 2, 2);
    chk(plane_en == 8'hFF, "R7 held in burst", int'(plane_en), 8'hFF);
    step(0, 0, 0, 0, 0, 2);
    chk(plane_en == 8'hC0 && act_prec == 2, "R7 applied after burst", int'(plane_en), 8'hC0);

    // R8 clamps
    step(0, 0, 0, 0, 0, 0);
    chk(act_prec == 1 && plane_en == 8'h80, "R8 zero clamp", int'(act_prec), 1);
    step(0, 0, 0, 0, 0, 12);
    chk(int'(act_prec) == PIX_W && plane_en == 8'hFF, "R8 high clamp", int'(act_prec), PIX_W);

    // R9: same-address read and write
    step(1, 7, 8'h3C, 0, 0, 8);
    step(1, 7, 8'hC3, 1, 7, 8);
    chk(rd_data == 8'h3C, "R9 old data", int'(rd_data), 8'h3C);
    step(0, 0, 0, 1, 7, 8);
    chk(rd_data == 8'hC3, "R9 new data", int'(rd_data), 8'hC3);

    // R4 sweep with all-ones pixel
    step(1, 9, 8'hFF, 0, 0, 8);
    for (int p = 1; p <= PIX_W; p++) begin
      step(0, 0, 0, 0, 0, p);
      step(0, 0, 0, 1, 9, p);
      chk(int'(rd_data) == top_mask(p), "R4 sweep", int'(rd_data), top_mask(p));
      chk(int'(idle) == PIX_W - p, "R6 sweep", int'(idle), PIX_W - p);
    end
    step(0, 0, 0, 0, 0, 8);

    // reset again mid-operation
    rst_n = 1'b0;
    @(negedge clk);
    chk(!rd_valid && plane_en == 8'hFF, "R1 re-reset", int'(plane_en), 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule